// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Register Bank

This block holds the control state for four general-purpose pins: a direction mask, a stored drive value, and a read-inversion mask. It also samples the pin levels through a two-stage synchronizer. A host reaches the bank through a simple register port. The port has a 2-bit register select, 8-bit write data with a write strobe, and a read strobe that loads an 8-bit read-data register. The pad side receives an output enable and a drive value for each pin, and returns the raw level of each pin.

Each register is eight bits wide, but only the low four bits hold state. On a read, the upper four bits are filled with that register's reset pattern. A read of the input register returns the synchronized pin levels, with each bit flipped where the inversion mask is set. A read of the drive register returns the stored flip-flop value, not the level seen on the pin. The input register cannot be written.

The bank has no state machine. Writes are decoded in one cycle, and reads are captured in one cycle. The reset is asynchronous and active low.

Top module: `gpio4_bank`

## Requirements
- R1: After reset, direction is 1111, drive is 1111 and inversion is 0000. So `pin_oe` is 0000, `pin_out` is 0000 and `rd_data` is 0x00.
- R2: Register select 0 is the input register, 1 is the drive register, 2 is the inversion mask and 3 is the direction register.
- R3: A write with select 0 changes no register and no pin output.
- R4: A direction bit of 1 makes its pin an input: `pin_oe` is 0 and `pin_out` is 0, whatever the drive bit holds. A direction bit of 0 makes its pin an output: `pin_oe` is 1 and `pin_out` equals the drive bit. Both outputs follow a write from the next clock edge.
- R5: On an input-register read, a result bit is the synchronized pin level XOR the matching inversion bit.
- R6: A drive-register read returns the stored drive bits, even when the pin level differs.
- R7: Write data bits 7:4 are ignored. On a read, bits 7:4 are 1111 for selects 0, 1 and 3, and 0000 for select 2.
- R8: The input register reflects pin levels whether each pin is an input or an output. A level must be present at two rising edges before the read edge to be returned. A read at either of those two edges returns the earlier level.
- R9: `rd_data` loads on the rising edge where `rd_en` is high and holds at all other times. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 4 | Raw pin levels |
| pin_oe | output | 4 | Per-pin output enable |
| pin_out | output | 4 | Per-pin drive value |

## Verification
The assertions assume that `reg_sel` and `wr_data` are stable and known on every edge where a strobe is high. They also assume that `pin_in` is a clean digital level at each clock edge. The stimulus changes all inputs only on the falling edge, and it holds pin levels for at least three edges before a read that expects them. The one exception is the latency test, which deliberately reads one and two edges after a pin change.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
    typedef enum logic [1:0] {
        SEL_INPUT  = 2'd0,
        SEL_DRIVE  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio4_pin_sync.sv
module gpio4_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '1;
                end else if (s == 0) begin
                    chain_q[s] <= raw_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio4_ctrl_regs.sv
module gpio4_ctrl_regs
    import gpio4_pkg::*;
#(
    parameter int PINS = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      sel,
    input  logic [DW-1:0]   wr_data,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] drv_q,
    output logic [PINS-1:0] inv_q
);
    logic [PINS-1:0] wr_bits;
    logic            hit_dir;
    logic            hit_drv;
    logic            hit_inv;

    assign wr_bits = wr_data[PINS-1:0];

    always_comb begin
        hit_dir = 1'b0;
        hit_drv = 1'b0;
        hit_inv = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(sel))
                SEL_INPUT:  ;
                SEL_DRIVE:  hit_drv = 1'b1;
                SEL_INVERT: hit_inv = 1'b1;
                SEL_DIR:    hit_dir = 1'b1;
                default:    ;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < PINS; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dir_q[b] <= 1'b1;
                    drv_q[b] <= 1'b1;
                    inv_q[b] <= 1'b0;
                end else begin
                    if (hit_dir) dir_q[b] <= wr_bits[b];
                    if (hit_drv) drv_q[b] <= wr_bits[b];
                    if (hit_inv) inv_q[b] <= wr_bits[b];
                end
            end
        end
    endgenerate

    // R3: a write with select 0 leaves every register unchanged
    p_input_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd0) |=> ($stable(dir_q) && $stable(drv_q) && $stable(inv_q)));

    // R6, R7: a drive write stores only the low bits
    p_drive_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd1) |=> (drv_q == $past(wr_data[PINS-1:0])));

    // R5: an inversion write stores the mask
    p_invert_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd2) |=> (inv_q == $past(wr_data[PINS-1:0])));

    // R9: no strobe, no change
    p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(drv_q) && $stable(inv_q)));
endmodule

// File: rtl/gpio4_read_mux.sv
module gpio4_read_mux
    import gpio4_pkg::*;
#(
    parameter int PINS = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [1:0]      sel,
    input  logic [PINS-1:0] pin_sync,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] drv_q,
    input  logic [PINS-1:0] inv_q,
    output logic [DW-1:0]   rd_data
);
    localparam int UPPER = DW - PINS;
    localparam logic [UPPER-1:0] FILL_ONES  = '1;
    localparam logic [UPPER-1:0] FILL_ZEROS = '0;

    logic [DW-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        unique case (reg_sel_e'(sel))
            SEL_INPUT:  rd_next = {FILL_ONES,  pin_sync ^ inv_q};
            SEL_DRIVE:  rd_next = {FILL_ONES,  drv_q};
            SEL_INVERT: rd_next = {FILL_ZEROS, inv_q};
            SEL_DIR:    rd_next = {FILL_ONES,  dir_q};
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R9: read data holds without a strobe
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7: inversion read has zero upper bits
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 2'd2) |=> (rd_data[DW-1:PINS] == FILL_ZEROS));

    // R7: other reads have ones in the upper bits
    p_upper_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel != 2'd2) |=> (rd_data[DW-1:PINS] == FILL_ONES));

    // R6: drive read returns the stored value
    p_drive_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 2'd1) |=> (rd_data[PINS-1:0] == $past(drv_q)));
endmodule

// File: rtl/gpio4_bank.sv
module gpio4_bank #(
    parameter int PINS        = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pin_out
);
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] drv_q;
    logic [PINS-1:0] inv_q;
    logic [PINS-1:0] pin_sync;

    gpio4_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pin_sync)
    );

    gpio4_ctrl_regs #(.PINS(PINS), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (reg_sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .drv_q   (drv_q),
        .inv_q   (inv_q)
    );

    gpio4_read_mux #(.PINS(PINS), .DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (reg_sel),
        .pin_sync (pin_sync),
        .dir_q    (dir_q),
        .drv_q    (drv_q),
        .inv_q    (inv_q),
        .rd_data  (rd_data)
    );

    genvar p;
    generate
        for (p = 0; p < PINS; p++) begin : g_pad
            assign pin_oe[p]  = ~dir_q[p];
            assign pin_out[p] = dir_q[p] ? 1'b0 : drv_q[p];
        end
    endgenerate

    // R4: a direction write sets the enables on the next edge
    p_dir_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3) |=> (pin_oe == ~$past(wr_data[PINS-1:0])));

    // R4: an input pin never drives high
    p_input_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // R3: a select-0 write leaves the pad outputs alone
    p_pads_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/test_gpio4_bank.sv
`timescale 1ns/1ps
module test_gpio4_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'hF;
    logic [3:0] pin_oe;
    logic [3:0] pin_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio4_bank i_gpio4_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] sel;
        logic [7:0] data;
        logic [3:0] pins;
        logic [7:0] exp_rd;
        logic [3:0] exp_oe;
        logic [3:0] exp_po;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 4'hA, 8'hFA, 4'h0, 4'h0, 4'd8}, // R2 R8 input read, all inputs
        '{1'b0, 2'd1, 8'h00, 4'hA, 8'hFF, 4'h0, 4'h0, 4'd1}, // R1 drive default
        '{1'b0, 2'd2, 8'h00, 4'hA, 8'h00, 4'h0, 4'h0, 4'd1}, // R1 inversion default
        '{1'b0, 2'd3, 8'h00, 4'hA, 8'hFF, 4'h0, 4'h0, 4'd1}, // R1 direction default
        '{1'b1, 2'd1, 8'h35, 4'hA, 8'h00, 4'h0, 4'h0, 4'd4}, // R4 drive ignored while input
        '{1'b0, 2'd1, 8'h00, 4'hA, 8'hF5, 4'h0, 4'h0, 4'd7}, // R7 upper write bits dropped
        '{1'b1, 2'd3, 8'hF0, 4'hA, 8'h00, 4'hF, 4'h5, 4'd4}, // R4 all outputs
        '{1'b0, 2'd3, 8'h00, 4'hA, 8'hF0, 4'hF, 4'h5, 4'd7}, // R7 direction readback
        '{1'b0, 2'd0, 8'h00, 4'h3, 8'hF3, 4'hF, 4'h5, 4'd8}, // R8 pins seen while outputs
        '{1'b0, 2'd1, 8'h00, 4'h3, 8'hF5, 4'hF, 4'h5, 4'd6}, // R6 stored value, not pins
        '{1'b1, 2'd2, 8'hA6, 4'h3, 8'h00, 4'hF, 4'h5, 4'd5}, // R5 inversion write
        '{1'b0, 2'd2, 8'h00, 4'h3, 8'h06, 4'hF, 4'h5, 4'd7}, // R7 inversion upper zeros
        '{1'b0, 2'd0, 8'h00, 4'h3, 8'hF5, 4'hF, 4'h5, 4'd5}, // R5 3 ^ 6
        '{1'b1, 2'd0, 8'h00, 4'h3, 8'h00, 4'hF, 4'h5, 4'd3}, // R3 write to input reg
        '{1'b0, 2'd1, 8'h00, 4'h3, 8'hF5, 4'hF, 4'h5, 4'd3}, // R3 drive unchanged
        '{1'b0, 2'd2, 8'h00, 4'h3, 8'h06, 4'hF, 4'h5, 4'd3}, // R3 inversion unchanged
        '{1'b0, 2'd3, 8'h00, 4'h3, 8'hF0, 4'hF, 4'h5, 4'd3}, // R3 direction unchanged
        '{1'b1, 2'd3, 8'h0C, 4'h3, 8'h00, 4'h3, 4'h1, 4'd4}, // R4 mixed direction
        '{1'b1, 2'd1, 8'h0A, 4'h3, 8'h00, 4'h3, 4'h2, 4'd4}, // R4 drive masked by direction
        '{1'b0, 2'd0, 8'h00, 4'h9, 8'hFF, 4'h3, 4'h2, 4'd5}, // R5 9 ^ 6
        '{1'b0, 2'd0, 8'h00, 4'h0, 8'hF6, 4'h3, 4'h2, 4'd8}  // R8 all pins low
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        pin_in = v.pins;
        repeat (3) @(negedge clk);
        reg_sel = v.sel;
        wr_data = v.data;
        wr_en   = v.wr;
        rd_en   = ~v.wr;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        if (!v.wr) check8($sformatf("R%0d rd_data", v.req), rd_data, v.exp_rd);
        check8($sformatf("R%0d pin_oe", v.req), {4'h0, pin_oe}, {4'h0, v.exp_oe});
        check8($sformatf("R%0d pin_out", v.req), {4'h0, pin_out}, {4'h0, v.exp_po});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1 pin_oe reset", {4'h0, pin_oe}, 8'h00);
        check8("R1 pin_out reset", {4'h0, pin_out}, 8'h00);
        check8("R1 rd_data reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9 read and write in one cycle returns the value from before the write
        reg_sel = 2'd1; wr_data = 8'h07; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check8("R9 read before write", rd_data, 8'hFA);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check8("R9 read after write", rd_data, 8'hF7);

        // R9 hold with no strobe, while pins and select change
        pin_in = 4'h5; reg_sel = 2'd0;
        repeat (4) @(negedge clk);
        check8("R9 rd_data holds", rd_data, 8'hF7);

        // R8 latency: pins 5 ^ inv 6 = 3 now synced; change pins to C
        pin_in = 4'hC;
        rd_en = 1'b1;
        @(negedge clk);
        check8("R8 first edge old", rd_data, 8'hF3);
        @(negedge clk);
        check8("R8 second edge old", rd_data, 8'hF3);
        @(negedge clk);
        rd_en = 1'b0;
        check8("R8 third edge new", rd_data, 8'hFA);

        // R1 reset mid-run restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        check8("R1 pin_oe after reset", {4'h0, pin_oe}, 8'h00);
        check8("R1 rd_data after reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        reg_sel = 2'd3; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check8("R1 direction after reset", rd_data, 8'hFF);
        reg_sel = 2'd2; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check8("R1 inversion after reset", rd_data, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule